// File: doc/BRIEF.md
# Host Command Decoder with Status Readback

This block turns command words from a host link into the configuration registers that steer a radar front end. Each command word holds an 8-bit opcode in its top byte and a value in its low half. Known opcodes load the detection threshold, the three-bit stream-enable mask or one of six chirp-timing registers. The register outputs go straight to the chirp sequencer and to the arbiter that sends data upstream. Any opcode outside the map is dropped.

The status opcode asks for a readback. The decoder flips a single toggle flop in the command clock domain. The readback clock domain synchronises that toggle and turns each level change into a one-cycle request. The readback side then takes a snapshot of every setting and sends it as a seven-word packet under a valid/ready handshake. Settings are treated as quasi-static across the crossing: every write that comes before a status command has settled before the toggle flips.

Top module: `hcd_top`

## Requirements
- R1: After reset, the outputs are: stream mask 3'b001, threshold 5000, long chirp 3000, long listen 13700, guard 17540, short chirp 50, short listen 17450, chirps per elevation 32. The packet valid output is low.
- R2: A command word has its opcode in bits [31:24] and its value in bits [15:0]. Bits [23:16] are not used. A word is acted on only in a clk_i cycle where cmd_valid_i is high. Without that strobe, no output changes.
- R3: Opcode 0x03 loads the threshold from the value field. The new value shows on cfar_thr_o after the next clk_i edge.
- R4: Opcode 0x04 loads the stream mask from value bits [2:0] and ignores the higher value bits.
- R5: Opcodes 0x10 to 0x15 load the timing registers in this order: long chirp, long listen, guard, short chirp, short listen, chirps per elevation. Each load is visible after the next clk_i edge.
- R6: Any other opcode except 0xFF changes no output and starts no packet.
- R7: Opcode 0xFF flips a toggle. In clk_rd_i, a two-flop synchroniser and an edge detector turn that flip into exactly one packet of exactly 7 words. sts_last_o is high on the seventh word only.
- R8: Word 0 has 0xC3 in [31:24], the stream mask in [18:16] and the threshold in [15:0]. Word k (1 to 6) has opcode 0x10+k-1 in [31:24] and that opcode's timing register in [15:0]. All other bits are zero.
- R9: While sts_valid_o is high and sts_ready_i is low, valid stays high and the data word stays unchanged. The packet moves to the next word only on a cycle where valid and ready are both high.
- R10: A status request that arrives while a packet is in flight is held. Exactly one further packet follows once the current packet ends.
- R11: The packet content is captured when the packet starts. Register writes made while it is being sent do not change it; the next packet shows them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command domain clock |
| rst_ni | input | 1 | Command domain async reset, active low |
| cmd_valid_i | input | 1 | Command word strobe |
| cmd_word_i | input | 32 | Opcode [31:24], value [15:0] |
| clk_rd_i | input | 1 | Readback domain clock |
| rst_rd_ni | input | 1 | Readback domain async reset, active low |
| sts_ready_i | input | 1 | Packet sink ready |
| cfar_thr_o | output | 16 | Detection threshold |
| stream_en_o | output | 3 | Stream-enable mask |
| chirp_long_o | output | 16 | Long chirp length |
| listen_long_o | output | 16 | Long listen length |
| guard_o | output | 16 | Guard length |
| chirp_short_o | output | 16 | Short chirp length |
| listen_short_o | output | 16 | Short listen length |
| chirps_per_elev_o | output | 16 | Chirps per elevation step |
| sts_valid_o | output | 1 | Packet word valid |
| sts_data_o | output | 32 | Packet word |
| sts_last_o | output | 1 | Final word of packet |

## Verification
A new status request and the sending of an earlier packet can fall in the same readback cycle. A register write can also land while a packet is still waiting to drain. The bench sets this up by holding sts_ready_i low once the first word appears. It then issues further status commands and timing or threshold writes before releasing the sink. It counts the words that come out and checks that there are exactly two back-to-back packets and no third. It also checks that the first packet still carries the values from before the writes.

// File: rtl/hcd_pkg.sv
package hcd_pkg;
  localparam int OP_W      = 8;
  localparam int N_TMG     = 6;
  localparam int PKT_WORDS = 1 + N_TMG;

  localparam logic [OP_W-1:0] OP_THR      = 8'h03;
  localparam logic [OP_W-1:0] OP_STREAM   = 8'h04;
  localparam logic [OP_W-1:0] OP_TMG_BASE = 8'h10;
  localparam logic [OP_W-1:0] OP_STATUS   = 8'hFF;
  localparam logic [OP_W-1:0] PKT_HDR     = 8'hC3;

  localparam logic [2:0] STREAM_RST = 3'b001;
  localparam int         THR_RST    = 5000;

  // timing index: 0 long chirp, 1 long listen, 2 guard, 3 short chirp, 4 short listen, 5 chirps/elev
  function automatic int tmg_rst(input int k);
    case (k)
      0:       return 3000;
      1:       return 13700;
      2:       return 17540;
      3:       return 50;
      4:       return 17450;
      default: return 32;
    endcase
  endfunction
endpackage

// File: rtl/hcd_regfile.sv
module hcd_regfile
  import hcd_pkg::*;
#(
  parameter int VAL_W  = 16,
  parameter int WORD_W = VAL_W + 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             cmd_valid_i,
  input  logic [WORD_W-1:0]                cmd_word_i,
  output logic [VAL_W-1:0]                 thr_o,
  output logic [2:0]                       stream_o,
  output logic [N_TMG-1:0][VAL_W-1:0]      tmg_o,
  output logic                             req_tgl_o
);
  logic [OP_W-1:0]  op;
  logic [VAL_W-1:0] val;
  assign op  = cmd_word_i[WORD_W-1 -: OP_W];
  assign val = cmd_word_i[VAL_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_o     <= VAL_W'(THR_RST);
      stream_o  <= STREAM_RST;
      req_tgl_o <= 1'b0;
    end else if (cmd_valid_i) begin
      if (op == OP_THR)    thr_o     <= val;
      if (op == OP_STREAM) stream_o  <= val[2:0];
      if (op == OP_STATUS) req_tgl_o <= ~req_tgl_o;
    end
  end

  for (genvar k = 0; k < N_TMG; k++) begin : g_tmg
    logic hit;
    assign hit = cmd_valid_i && (op == OP_TMG_BASE + OP_W'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  tmg_o[k] <= VAL_W'(tmg_rst(k));
      else if (hit) tmg_o[k] <= val;
    end
  end
endmodule

// File: rtl/hcd_tgl_sync.sv
module hcd_tgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic pulse_o
);
  // sh_q[STAGES-1:0] synchroniser, sh_q[STAGES] previous synced level
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], tgl_i};
  end

  assign pulse_o = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/hcd_status_tx.sv
module hcd_status_tx
  import hcd_pkg::*;
#(
  parameter int VAL_W  = 16,
  parameter int WORD_W = VAL_W + 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic [VAL_W-1:0]            thr_i,
  input  logic [2:0]                  stream_i,
  input  logic [N_TMG-1:0][VAL_W-1:0] tmg_i,
  input  logic                        ready_i,
  output logic                        valid_o,
  output logic [WORD_W-1:0]           data_o,
  output logic                        last_o
);
  localparam int IDX_W = $clog2(PKT_WORDS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PKT_WORDS - 1);

  logic [WORD_W-1:0] snap    [PKT_WORDS];
  logic [WORD_W-1:0] words_q [PKT_WORDS];
  logic [IDX_W-1:0]  idx_q;
  logic              busy_q, pend_q;
  logic              fire, done, start;

  assign snap[0] = {PKT_HDR, 5'b0, stream_i, thr_i};
  for (genvar k = 0; k < N_TMG; k++) begin : g_snap
    assign snap[k+1] = {OP_TMG_BASE + OP_W'(k), 8'h00, tmg_i[k]};
  end

  assign last_o  = busy_q && (idx_q == IDX_LAST);
  assign valid_o = busy_q;
  assign data_o  = words_q[idx_q];
  assign fire    = busy_q && ready_i;
  assign done    = fire && last_o;
  assign start   = (req_i || pend_q) && (!busy_q || done);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      // a request seen during a packet waits; several collapse into one
      pend_q <= start ? (req_i && pend_q) : (pend_q || (req_i && busy_q));
      if (start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (done) begin
        busy_q <= 1'b0;
      end else if (fire) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PKT_WORDS; i++) words_q[i] <= '0;
    end else if (start) begin
      for (int i = 0; i < PKT_WORDS; i++) words_q[i] <= snap[i];
    end
  end
endmodule

// File: rtl/hcd_top.sv
module hcd_top
  import hcd_pkg::*;
#(
  parameter int VAL_W    = 16,
  parameter int WORD_W   = VAL_W + 16,
  parameter int SYNC_STG = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [WORD_W-1:0] cmd_word_i,
  input  logic              clk_rd_i,
  input  logic              rst_rd_ni,
  input  logic              sts_ready_i,
  output logic [VAL_W-1:0]  cfar_thr_o,
  output logic [2:0]        stream_en_o,
  output logic [VAL_W-1:0]  chirp_long_o,
  output logic [VAL_W-1:0]  listen_long_o,
  output logic [VAL_W-1:0]  guard_o,
  output logic [VAL_W-1:0]  chirp_short_o,
  output logic [VAL_W-1:0]  listen_short_o,
  output logic [VAL_W-1:0]  chirps_per_elev_o,
  output logic              sts_valid_o,
  output logic [WORD_W-1:0] sts_data_o,
  output logic              sts_last_o
);
  logic [N_TMG-1:0][VAL_W-1:0] tmg;
  logic                        req_tgl, req_pulse;

  hcd_regfile #(.VAL_W(VAL_W), .WORD_W(WORD_W)) regs_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_word_i  (cmd_word_i),
    .thr_o       (cfar_thr_o),
    .stream_o    (stream_en_o),
    .tmg_o       (tmg),
    .req_tgl_o   (req_tgl)
  );

  hcd_tgl_sync #(.STAGES(SYNC_STG)) sync_i (
    .clk_i   (clk_rd_i),
    .rst_ni  (rst_rd_ni),
    .tgl_i   (req_tgl),
    .pulse_o (req_pulse)
  );

  // settings cross as quasi-static: every write precedes the toggle that samples it
  hcd_status_tx #(.VAL_W(VAL_W), .WORD_W(WORD_W)) tx_i (
    .clk_i    (clk_rd_i),
    .rst_ni   (rst_rd_ni),
    .req_i    (req_pulse),
    .thr_i    (cfar_thr_o),
    .stream_i (stream_en_o),
    .tmg_i    (tmg),
    .ready_i  (sts_ready_i),
    .valid_o  (sts_valid_o),
    .data_o   (sts_data_o),
    .last_o   (sts_last_o)
  );

  assign chirp_long_o      = tmg[0];
  assign listen_long_o     = tmg[1];
  assign guard_o           = tmg[2];
  assign chirp_short_o     = tmg[3];
  assign listen_short_o    = tmg[4];
  assign chirps_per_elev_o = tmg[5];
endmodule

// File: rtl/hcd_checker.sv
module hcd_checker
  import hcd_pkg::*;
#(
  parameter int VAL_W  = 16,
  parameter int WORD_W = VAL_W + 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [WORD_W-1:0] cmd_word_i,
  input logic              clk_rd_i,
  input logic              rst_rd_ni,
  input logic              sts_ready_i,
  input logic [VAL_W-1:0]  cfar_thr_o,
  input logic [2:0]        stream_en_o,
  input logic [VAL_W-1:0]  chirp_long_o,
  input logic [VAL_W-1:0]  chirps_per_elev_o,
  input logic [VAL_W-1:0]  guard_o,
  input logic              sts_valid_o,
  input logic [WORD_W-1:0] sts_data_o,
  input logic              sts_last_o
);
  logic [OP_W-1:0] op;
  logic            wr_known;
  logic [2:0]      wcnt_q;

  assign op       = cmd_word_i[WORD_W-1 -: OP_W];
  assign wr_known = cmd_valid_i && (op == OP_THR || op == OP_STREAM ||
                    (op >= OP_TMG_BASE && op <= OP_TMG_BASE + OP_W'(N_TMG - 1)));

  always_ff @(posedge clk_rd_i or negedge rst_rd_ni) begin
    if (!rst_rd_ni)                                   wcnt_q <= '0;
    else if (sts_valid_o && sts_ready_i && sts_last_o) wcnt_q <= '0;
    else if (sts_valid_o && sts_ready_i)              wcnt_q <= wcnt_q + 1'b1;
  end

  assert_thr_wr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && op == OP_THR |=> cfar_thr_o == $past(cmd_word_i[VAL_W-1:0]));

  assert_stream_wr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && op == OP_STREAM |=> stream_en_o == $past(cmd_word_i[2:0]));

  assert_tmg_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && op == OP_TMG_BASE |=> chirp_long_o == $past(cmd_word_i[VAL_W-1:0]));

  assert_tmg_final_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && op == OP_TMG_BASE + 8'h05 |=> chirps_per_elev_o == $past(cmd_word_i[VAL_W-1:0]));

  // R2 and R6: no known write -> settings hold
  assert_ignore_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_known |=> $stable(cfar_thr_o) && $stable(stream_en_o) && $stable(chirp_long_o)
                  && $stable(guard_o) && $stable(chirps_per_elev_o));

  assert_hold_R9: assert property (@(posedge clk_rd_i) disable iff (!rst_rd_ni)
    sts_valid_o && !sts_ready_i |=> sts_valid_o && $stable(sts_data_o));

  assert_header_R8: assert property (@(posedge clk_rd_i) disable iff (!rst_rd_ni)
    sts_valid_o && wcnt_q == 3'd0 |-> sts_data_o[WORD_W-1 -: OP_W] == PKT_HDR);

  assert_len_R7: assert property (@(posedge clk_rd_i) disable iff (!rst_rd_ni)
    sts_valid_o |-> (sts_last_o == (wcnt_q == 3'd6)));
endmodule

bind hcd_top hcd_checker #(.VAL_W(VAL_W), .WORD_W(WORD_W)) chk_i (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .cmd_valid_i       (cmd_valid_i),
  .cmd_word_i        (cmd_word_i),
  .clk_rd_i          (clk_rd_i),
  .rst_rd_ni         (rst_rd_ni),
  .sts_ready_i       (sts_ready_i),
  .cfar_thr_o        (cfar_thr_o),
  .stream_en_o       (stream_en_o),
  .chirp_long_o      (chirp_long_o),
  .chirps_per_elev_o (chirps_per_elev_o),
  .guard_o           (guard_o),
  .sts_valid_o       (sts_valid_o),
  .sts_data_o        (sts_data_o),
  .sts_last_o        (sts_last_o)
);

// File: tb/hcd_top_tb_top.sv
`timescale 1ns/100ps
module hcd_top_tb_top;
  logic        clk = 1'b0, clk_rd = 1'b0;
  logic        rst_n = 1'b0, rst_rd_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        sts_ready = 1'b0;
  logic [15:0] thr_o, cl_o, ll_o, g_o, cs_o, ls_o, cpe_o;
  logic [2:0]  str_o;
  logic        v_o, l_o;
  logic [31:0] d_o;

  always #4   clk    = ~clk;
  always #6.5 clk_rd = ~clk_rd;

  hcd_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_word_i(cmd_word),
    .clk_rd_i(clk_rd), .rst_rd_ni(rst_rd_n), .sts_ready_i(sts_ready),
    .cfar_thr_o(thr_o), .stream_en_o(str_o), .chirp_long_o(cl_o), .listen_long_o(ll_o),
    .guard_o(g_o), .chirp_short_o(cs_o), .listen_short_o(ls_o), .chirps_per_elev_o(cpe_o),
    .sts_valid_o(v_o), .sts_data_o(d_o), .sts_last_o(l_o)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  logic [15:0] m_thr = 16'd5000;
  logic [2:0]  m_str = 3'b001;
  logic [15:0] m_tmg [6] = '{16'd3000, 16'd13700, 16'd17540, 16'd50, 16'd17450, 16'd32};
  logic [31:0] exp_w [14];
  logic [31:0] got_w [16];
  logic        got_l [16];

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] op, input logic [15:0] val, input bit vld = 1'b1);
    @(negedge clk);
    cmd_valid = vld;
    cmd_word  = {op, 8'h5A, val};
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = '0;
  endtask

  // expected packet from the bench model (R8)
  task automatic fill_exp(input int base);
    exp_w[base] = {8'hC3, 5'b0, m_str, m_thr};
    for (int k = 0; k < 6; k++) exp_w[base+k+1] = {8'h10 + 8'(k), 8'h00, m_tmg[k]};
  endtask

  task automatic chk_regs(input string r);
    chk(r, {29'b0, str_o}, {29'b0, m_str});
    chk(r, {16'b0, thr_o}, {16'b0, m_thr});
    chk(r, {16'b0, cl_o},  {16'b0, m_tmg[0]});
    chk(r, {16'b0, ll_o},  {16'b0, m_tmg[1]});
    chk(r, {16'b0, g_o},   {16'b0, m_tmg[2]});
    chk(r, {16'b0, cs_o},  {16'b0, m_tmg[3]});
    chk(r, {16'b0, ls_o},  {16'b0, m_tmg[4]});
    chk(r, {16'b0, cpe_o}, {16'b0, m_tmg[5]});
  endtask

  // mode 0: always ready, mode 1: ready two of three cycles
  task automatic collect(input int nw, input int mode, output int got_n);
    logic [31:0] prev_d = '0;
    bit prev_stall = 0;
    int cyc = 0;
    got_n = 0;
    while (got_n < nw && cyc < 600) begin
      @(negedge clk_rd);
      sts_ready = (mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      if (prev_stall) begin
        chk("R9 valid held", {31'b0, v_o}, 32'd1);
        chk("R9 data held", d_o, prev_d);
      end
      if (v_o && sts_ready) begin
        got_w[got_n] = d_o;
        got_l[got_n] = l_o;
        got_n++;
      end
      prev_stall = v_o && !sts_ready;
      prev_d = d_o;
      cyc++;
    end
    @(negedge clk_rd);
    sts_ready = 1'b0;
  endtask

  task automatic chk_pkts(input string r, input int n);
    for (int i = 0; i < n; i++) begin
      chk(r, got_w[i], exp_w[i]);
      chk({r, " last"}, {31'b0, got_l[i]}, {31'b0, (i % 7) == 6});
    end
  endtask

  task automatic wait_valid(input string r);
    int n = 0;
    while (!v_o && n < 60) begin @(negedge clk_rd); n++; end
    chk(r, {31'b0, v_o}, 32'd1);
  endtask

  task automatic chk_quiet(input string r);
    bit seen = 0;
    repeat (30) begin @(negedge clk_rd); if (v_o) seen = 1; end
    chk(r, {31'b0, seen}, 32'd0);
  endtask

  task automatic t_reset;
    chk_regs("R1 reset");
    chk("R1 valid low", {31'b0, v_o}, 32'd0);
  endtask

  task automatic t_no_valid;
    send(8'h03, 16'd999, 1'b0);
    send(8'h10, 16'd999, 1'b0);
    chk_regs("R2 no strobe");
  endtask

  task automatic t_writes;
    send(8'h03, 16'd1234);   m_thr = 16'd1234;
    chk("R3 thr", {16'b0, thr_o}, 32'd1234);
    send(8'h04, 16'hFFFE);   m_str = 3'b110;
    chk("R4 stream", {29'b0, str_o}, 32'd6);
    for (int k = 0; k < 6; k++) begin
      send(8'h10 + 8'(k), 16'h0100 + 16'(k * 17));
      m_tmg[k] = 16'h0100 + 16'(k * 17);
    end
    chk_regs("R5 timing");
  endtask

  task automatic t_unknown;
    send(8'h00, 16'hAAAA);
    send(8'h05, 16'hAAAA);
    send(8'h0F, 16'hAAAA);
    send(8'h16, 16'hAAAA);
    send(8'hFE, 16'hAAAA);
    chk_regs("R6 unknown");
    chk_quiet("R6 no packet");
  endtask

  task automatic t_status;
    int n;
    fill_exp(0);
    send(8'hFF, 16'h0);
    collect(7, 0, n);
    chk("R7 count", 32'(n), 32'd7);
    chk_pkts("R8 word", 7);
    chk_quiet("R7 single packet");
  endtask

  task automatic t_backpressure;
    int n;
    send(8'h03, 16'hBEEF); m_thr = 16'hBEEF;
    send(8'h04, 16'h0003); m_str = 3'b011;
    fill_exp(0);
    send(8'hFF, 16'h0);
    collect(7, 1, n);
    chk("R9 count", 32'(n), 32'd7);
    chk_pkts("R9 word", 7);
  endtask

  task automatic t_snapshot;
    int n;
    fill_exp(0);
    send(8'hFF, 16'h0);
    wait_valid("R11 start");
    send(8'h15, 16'd77);  m_tmg[5] = 16'd77;
    send(8'h03, 16'd42);  m_thr = 16'd42;
    collect(7, 0, n);
    chk_pkts("R11 old values", 7);
    fill_exp(0);
    send(8'hFF, 16'h0);
    collect(7, 0, n);
    chk_pkts("R11 new values", 7);
  endtask

  task automatic t_overlap;
    int n;
    fill_exp(0);
    fill_exp(7);
    send(8'hFF, 16'h0);
    wait_valid("R10 first");
    send(8'hFF, 16'h0);
    repeat (10) @(negedge clk_rd);
    send(8'hFF, 16'h0);
    repeat (10) @(negedge clk_rd);
    collect(14, 0, n);
    chk("R10 count", 32'(n), 32'd14);
    chk_pkts("R10 word", 14);
    chk_quiet("R10 no third packet");
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk_rd);
    rst_rd_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_no_valid();
    t_writes();
    t_unknown();
    t_status();
    t_backpressure();
    t_snapshot();
    t_overlap();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule